// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block lets one host bus master reach a large bank of 8-bit configuration parameters through three directly decoded host locations. The host bus carries a 3-bit address, a 16-bit write data bus, a read data bus and separate read and write strobes. Two locations hold a parameter index. The third is a data window: a write to it stores a byte into the parameter the index selects, and a read from it returns that parameter.

A mode input sets the width of the host bus. With an 8-bit host, the index is loaded one byte at a time: the low byte through one location and the high byte through another. With a 16-bit host, a single write to the low index location loads the whole index. The parameter array is a synchronous memory with `2**PAR_AW` entries. Index bits above `PAR_AW` are not decoded, so those addresses alias. Because only one master drives the bus, the block does no arbitration.

Top module: `cfgw_port`

## Requirements
- R1: After reset `rd_valid` is 0, `rd_data` is 0 and the parameter index is 0, so a data-window access before any index write reaches parameter 0.
- R2: With `wide_mode`=0, a write to host address 3'b000 loads index bits [7:0] from `host_wdata[7:0]`, and a write to host address 3'b001 loads index bits [15:8] from `host_wdata[7:0]`. Each write leaves the other byte unchanged.
- R3: With `wide_mode`=1, one write to host address 3'b000 loads all 16 index bits from `host_wdata[15:0]`.
- R4: A write to host address 3'b010 stores `host_wdata[7:0]` into the parameter selected by the index. A read issued in the next cycle returns the new value.
- R5: A read strobe at host address 3'b010 in cycle t sets `rd_valid` to 1 in cycle t+1 only, with `rd_data[7:0]` holding the selected parameter.
- R6: `rd_data[15:8]` is always 0, and all of `rd_data` is 0 whenever `rd_valid` is 0.
- R7: With `wide_mode`=0, `host_wdata[15:8]` has no effect on any write.
- R8: The index keeps its value until host address 3'b000 or 3'b001 is written again. Reads and writes of the data window do not change it.
- R9: Writes to host addresses 3'b011 through 3'b111 change no state. Reads of any address other than 3'b010 leave `rd_valid` at 0.
- R10: Only index bits [PAR_AW-1:0] select the parameter. Indices that differ only above that width reach the same parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wide_mode | input | 1 | 1: 16-bit host bus, 0: 8-bit host bus |
| host_addr | input | 3 | Host location: 000 index low, 001 index high, 010 data window |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| rd_data | output | 16 | Read data, valid when rd_valid is 1 |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |

## Verification
A bench configuration with 512 parameters is swept in full three times. The first pass fills every parameter through byte-wise index writes in 8-bit mode, with junk in the upper data byte, and reads each one back at once. The second pass reads all of them through single 16-bit index writes, which shows that both index paths build the same address. The third pass sets index bits above the array width, which separates aliasing from full decoding. Directed cases then cover a low-byte-only index update, repeated data-window accesses against a held index, and writes and reads at the undecoded locations, where a stray state change or valid pulse would show.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int HOST_DW = 16;
  localparam int PAR_DW  = 8;
  localparam logic [2:0] HA_IDX_LO = 3'b000;
  localparam logic [2:0] HA_IDX_HI = 3'b001;
  localparam logic [2:0] HA_DATA   = 3'b010;
endpackage

// File: rtl/cfgw_rst_sync.sv
module cfgw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_n;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cfgw_index_reg.sv
module cfgw_index_reg #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] idx
);
  localparam int NBYTES = IDX_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] byte_n;
    logic [7:0] byte_q;
    logic       byte_en;

    if (b == 0) begin : g_lo
      always_comb begin
        byte_en = ld_lo;
        byte_n  = wdata[7:0];
      end
    end else if (b == 1) begin : g_hi
      always_comb begin
        byte_en = ld_hi | (ld_lo & wide);
        byte_n  = ld_hi ? wdata[7:0] : wdata[15:8];
      end
    end else begin : g_up
      always_comb begin
        byte_en = ld_lo & wide;
        byte_n  = wdata[b*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'h00;
      else if (byte_en) byte_q <= byte_n;
    end

    assign idx[b*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/cfgw_param_mem.sv
module cfgw_param_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_n;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    rd_n = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (re) rd_q <= rd_n;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/cfgw_port.sv
module cfgw_port
  import cfgw_pkg::*;
#(
  parameter int PAR_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic [2:0]         host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic               host_wr,
  input  logic               host_rd,
  output logic [HOST_DW-1:0] rd_data,
  output logic               rd_valid
);
  localparam int PAD_W = HOST_DW - PAR_DW;

  logic               srst_n;
  logic               ld_lo;
  logic               ld_hi;
  logic               dat_wr;
  logic               dat_rd;
  logic [HOST_DW-1:0] idx;
  logic [PAR_DW-1:0]  par_q;
  logic               rv_n;
  logic               rv_q;

  cfgw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    ld_lo  = host_wr && (host_addr == HA_IDX_LO);
    ld_hi  = host_wr && (host_addr == HA_IDX_HI);
    dat_wr = host_wr && (host_addr == HA_DATA);
    dat_rd = host_rd && (host_addr == HA_DATA);
  end

  cfgw_index_reg #(.IDX_W(HOST_DW)) u_idx (
    .clk   (clk),
    .rst_n (srst_n),
    .wide  (wide_mode),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .wdata (host_wdata),
    .idx   (idx)
  );

  if (PAR_AW < HOST_DW) begin : g_alias
    logic unused_idx_hi;
    assign unused_idx_hi = ^idx[HOST_DW-1:PAR_AW];
  end

  cfgw_param_mem #(.AW(PAR_AW), .DW(PAR_DW)) u_mem (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (dat_wr),
    .re    (dat_rd),
    .addr  (idx[PAR_AW-1:0]),
    .wdata (host_wdata[PAR_DW-1:0]),
    .rdata (par_q)
  );

  always_comb begin
    rv_n = dat_rd;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rv_q <= 1'b0;
    else         rv_q <= rv_n;
  end

  assign rd_valid = rv_q;
  assign rd_data  = rv_q ? {{PAD_W{1'b0}}, par_q} : '0;
endmodule

// File: rtl/cfgw_port_chk.sv
module cfgw_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wide_mode,
  input logic [2:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic        host_wr,
  input logic        host_rd,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic [15:0] idx
);
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'b010) |=> rd_valid);

  // R9
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_addr == 3'b010) |=> !rd_valid);

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == 8'h00);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 16'h0000);

  // R3
  wide_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'b000 && wide_mode) |=> idx == $past(host_wdata));

  // R7
  narrow_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'b000 && !wide_mode) |=>
      (idx[7:0] == $past(host_wdata[7:0])) && (idx[15:8] == $past(idx[15:8])));

  // R8
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && (host_addr == 3'b000 || host_addr == 3'b001)) |=> $stable(idx));

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (rd_valid == 1'b0 && idx == 16'h0000);
    end
  end
endmodule

bind cfgw_port cfgw_port_chk u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .wide_mode  (wide_mode),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .idx        (idx)
);

// File: tb/sim_cfgw_port.sv
`timescale 1ns/1ps
module sim_cfgw_port;
  localparam int AW = 9;
  localparam int NPAR = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode;
  logic [2:0]  host_addr;
  logic [15:0] host_wdata;
  logic        host_wr;
  logic        host_rd;
  logic [15:0] rd_data;
  logic        rd_valid;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  cfgw_port #(.PAR_AW(AW)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_mode  (wide_mode),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  function automatic logic [7:0] pval(input int a);
    return 8'((a * 37) + ((a >> 8) * 101) + 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  // issues a read, samples the returned cycle and the one after it
  task automatic hrd(input logic [2:0] a, output logic [15:0] d,
                     output logic v1, output logic v0);
    @(negedge clk);
    host_addr = a;
    host_rd   = 1'b1;
    @(negedge clk);
    host_rd   = 1'b0;
    v1 = rd_valid;
    d  = rd_data;
    @(negedge clk);
    v0 = rd_valid;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] exp);
    logic [15:0] d;
    logic v1, v0;
    hrd(3'b010, d, v1, v0);
    chk(req, {15'd0, v1}, 32'd1);
    chk(req, d, {16'd0, 8'h00, exp});
    chk({req, " pulse"}, {15'd0, v0}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic v1, v0;
    rst_n = 1'b0;
    wide_mode = 1'b0;
    host_addr = 3'b000;
    host_wdata = 16'h0000;
    host_wr = 1'b0;
    host_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 rd_data", {16'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: index starts at 0
    hwr(3'b010, 16'h003C);
    rd_expect("R1 idx0 read", 8'h3C);
    wide_mode = 1'b1;
    hwr(3'b000, 16'h0000);
    rd_expect("R1 idx0 confirm", 8'h3C);

    // R2 R4 R5 R7: narrow fill with junk upper bytes, immediate readback
    wide_mode = 1'b0;
    for (int a = 0; a < NPAR; a++) begin
      hwr(3'b000, {8'hA5, 8'(a)});
      hwr(3'b001, {8'h5A, 8'(a >> 8)});
      hwr(3'b010, {8'hFF, pval(a)});
      rd_expect("R4 narrow readback", pval(a));
    end

    // R3: single wide index write
    wide_mode = 1'b1;
    for (int a = 0; a < NPAR; a++) begin
      hwr(3'b000, 16'(a));
      rd_expect("R3 wide index", pval(a));
    end

    // R10: bits above the array width do not decode
    for (int a = 0; a < NPAR; a++) begin
      hwr(3'b000, 16'(a) | 16'hFE00);
      rd_expect("R10 alias", pval(a));
    end

    // R2: low-byte update keeps the high byte
    wide_mode = 1'b0;
    hwr(3'b001, 16'h0001);
    hwr(3'b000, 16'h0003);
    rd_expect("R2 hi+lo", pval(259));
    hwr(3'b000, 16'hFF04);
    rd_expect("R2 lo only", pval(260));

    // R8: data accesses leave index alone
    rd_expect("R8 repeat read", pval(260));
    hwr(3'b010, 16'h00C7);
    rd_expect("R8 after write", 8'hC7);
    rd_expect("R8 again", 8'hC7);

    // R9: undecoded writes and non-data reads
    hwr(3'b000, 16'h0007);
    hwr(3'b001, 16'h0000);
    for (int a = 3; a < 8; a++) begin
      hwr(3'(a), 16'h0099);
    end
    rd_expect("R9 stray writes", pval(7));
    for (int a = 0; a < 8; a++) begin
      if (a != 2) begin
        hrd(3'(a), d, v1, v0);
        chk("R9 no valid", {31'd0, v1}, 32'd0);
        chk("R6 idle zero", {16'd0, d}, 32'd0);
      end
    end
    rd_expect("R9 index intact", pval(7));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule